// File: doc/BRIEF.md
# Power-On and External Reset Sequencer

This block generates the processor core's internal reset from three conditions: an asynchronous power-up reset from the analog supply monitor, a flag saying the oscillator is running, and the raw active-low external reset pin. After power-up, the core is held in reset until the oscillator is detected. A fixed start-up delay then runs, and after it the external pin must read high. Once the core is running, a low pulse on the external pin puts it back into reset, but only if the pulse lasts long enough. When the pin goes high again, the core restarts without repeating the start-up delay.

The pin passes through a two-flop synchronizer and then a symmetric consecutive-sample filter. The filter stands in for an input buffer with hysteresis. Its filtered level flips only after `MIN_LOW` consecutive synchronized samples disagree with it. This applies in both directions, so short glitches are rejected whether the pin is low or high. The power-up input is for initial power-up only and is not a supply-drop detector. The sequencer has four states: waiting for the oscillator, counting the timeout, waiting for the pin, and running. The internal reset is driven high in every state except running.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Asserting `por_in` drives `core_rst` high at once, without waiting for a clock edge. It also returns the sequencer to waiting for the oscillator, so the whole start-up delay is repeated after `por_in` falls.
- R2: After `por_in` falls, `core_rst` stays high for as long as `osc_ok` stays low.
- R3: Let edge E0 be the first rising clock edge after `por_in` falls at which `osc_ok` is sampled high. If the pin is high, `core_rst` falls at edge E0 + `TIMEOUT_CYC` (1920 by default) and not earlier.
- R4: If the filtered pin is low when the timeout ends, `core_rst` stays high until the pin goes high. It then falls at the (`MIN_LOW`+3)-th rising edge after the pin rises.
- R5: While running, a low level on `ext_rst_n` of at least `MIN_LOW` clock cycles (4 by default) raises `core_rst` at the (`MIN_LOW`+3)-th rising edge after the pin falls.
- R6: While running, a low pulse shorter than `MIN_LOW` cycles never raises `core_rst`.
- R7: After an external reset, `core_rst` falls at the (`MIN_LOW`+3)-th rising edge after the pin rises. The `TIMEOUT_CYC` delay is not repeated.
- R8: While held in reset by the pin, a high glitch shorter than `MIN_LOW` cycles never lowers `core_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| por_in | input | 1 | Asynchronous power-up reset, active high |
| osc_ok | input | 1 | Oscillator detected, synchronous to `clk` |
| ext_rst_n | input | 1 | Raw external reset pin, active low, asynchronous |
| core_rst | output | 1 | Internal reset to the core, active high |

## Verification
If the state is wrong, `core_rst` goes wrong on the very cycle the state is entered, because the output decodes the state with no further register. A timeout counter that is off by one moves the release edge by exactly one cycle, so the bench samples either side of edge E0+1920. A filter counter fault shifts the assert or release edge away from `MIN_LOW`+3. It can also let a pulse or glitch one cycle too short get through. A state that skips the pin check shows up as a release while the pin is still low.

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int unsigned TIMEOUT_CYC = 1920,
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned MIN_LOW     = 4
) (
  input  logic clk,
  input  logic por_in,
  input  logic osc_ok,
  input  logic ext_rst_n,
  output logic core_rst
);
  localparam int unsigned FW = $clog2(MIN_LOW + 1);

  typedef enum logic [1:0] {ST_OSC = 2'd0, ST_TMO = 2'd1, ST_PIN = 2'd2, ST_RUN = 2'd3} st_e;

  st_e            st;
  logic [CNT_W-1:0] tcnt;
  logic [1:0]     sync;
  logic           filt;
  logic [FW-1:0]  fcnt;

  always_ff @(posedge clk or posedge por_in)
    if (por_in) sync <= 2'b00;
    else        sync <= {sync[0], ext_rst_n};

  always_ff @(posedge clk or posedge por_in)
    if (por_in) begin
      filt <= 1'b0;
      fcnt <= '0;
    end else if (sync[1] == filt) begin
      fcnt <= '0;
    end else if (fcnt == FW'(MIN_LOW - 1)) begin
      filt <= sync[1];
      fcnt <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
    end

  always_ff @(posedge clk or posedge por_in)
    if (por_in) begin
      st   <= ST_OSC;
      tcnt <= '0;
    end else begin
      case (st)
        ST_OSC: if (osc_ok) begin
          st   <= ST_TMO;
          tcnt <= '0;
        end
        ST_TMO: if (tcnt == CNT_W'(TIMEOUT_CYC - 1)) st <= filt ? ST_RUN : ST_PIN;
                else tcnt <= tcnt + 1'b1;
        ST_PIN: if (filt) st <= ST_RUN;
        default: if (!filt) st <= ST_PIN;
      endcase
    end

  assign core_rst = (st != ST_RUN);
endmodule

module rst_seq_ctrl_chk #(
  parameter int unsigned TIMEOUT_CYC = 1920,
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned MIN_LOW     = 4,
  parameter int unsigned FW          = 3
) (
  input logic             clk,
  input logic             por_in,
  input logic             osc_ok,
  input logic             core_rst,
  input logic [1:0]       st,
  input logic [CNT_W-1:0] tcnt,
  input logic             filt,
  input logic [FW-1:0]    fcnt
);
  // R1
  por_holds_chk: assert property (@(posedge clk) por_in |-> core_rst);

  // R2
  osc_wait_chk: assert property (@(posedge clk) disable iff (por_in)
    (st == 2'd0 && !osc_ok) |=> (st == 2'd0 && core_rst));

  // R3
  tmo_bound_chk: assert property (@(posedge clk) disable iff (por_in)
    tcnt < CNT_W'(TIMEOUT_CYC));

  // R5
  rst_rise_chk: assert property (@(posedge clk) disable iff (por_in)
    $rose(core_rst) |-> !$past(filt));

  // R7
  rst_fall_chk: assert property (@(posedge clk) disable iff (por_in)
    $fell(core_rst) |-> $past(filt));

  // R6
  filt_qual_chk: assert property (@(posedge clk) disable iff (por_in)
    !$stable(filt) |-> $past(fcnt) == FW'(MIN_LOW - 1));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W), .MIN_LOW(MIN_LOW), .FW(FW)
) chk_i (
  .clk(clk), .por_in(por_in), .osc_ok(osc_ok), .core_rst(core_rst),
  .st(st), .tcnt(tcnt), .filt(filt), .fcnt(fcnt)
);

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
  localparam int TMO = 1920;
  localparam int ML  = 4;
  localparam int LAT = ML + 3;

  logic clk = 1'b0;
  logic por_in = 1'b1, osc_ok = 1'b0, ext_rst_n = 1'b1;
  logic core_rst;
  int total = 0, bad = 0;

  rst_seq_ctrl #(.TIMEOUT_CYC(TMO), .CNT_W(11), .MIN_LOW(ML)) dut_i (
    .clk(clk), .por_in(por_in), .osc_ok(osc_ok), .ext_rst_n(ext_rst_n), .core_rst(core_rst));

  always #2 clk = ~clk;

  function automatic logic exp_hit(int w);
    return w >= ML;
  endfunction

  task automatic chk(logic act, logic exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(int n, logic lvl, output logic seen);
    seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (core_rst === lvl) seen = 1'b1;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic seen;
    void'($urandom(32'd2024));
    step(3);
    chk(core_rst, 1'b1, "R1 reset state");
    por_in = 1'b0;
    step(30);
    chk(core_rst, 1'b1, "R2 no oscillator");
    osc_ok = 1'b1;
    step(TMO);
    chk(core_rst, 1'b1, "R3 before timeout end");
    step(1);
    chk(core_rst, 1'b0, "R3 timeout end");

    ext_rst_n = 1'b0;
    watch(ML - 1, 1'b1, seen);
    ext_rst_n = 1'b1;
    chk(seen, 1'b0, "R6 short pulse");
    watch(15, 1'b1, seen);
    chk(seen, 1'b0, "R6 short pulse settle");

    ext_rst_n = 1'b0;
    step(LAT - 1);
    chk(core_rst, 1'b0, "R5 before assert");
    step(1);
    chk(core_rst, 1'b1, "R5 assert edge");
    step(10);
    ext_rst_n = 1'b1;
    step(LAT - 1);
    chk(core_rst, 1'b1, "R7 before release");
    step(1);
    chk(core_rst, 1'b0, "R7 release no timeout");

    ext_rst_n = 1'b0;
    step(12);
    ext_rst_n = 1'b1;
    step(ML - 1);
    ext_rst_n = 1'b0;
    watch(12, 1'b0, seen);
    chk(seen, 1'b0, "R8 high glitch");
    ext_rst_n = 1'b1;
    step(LAT);
    chk(core_rst, 1'b0, "R8 real release");

    por_in = 1'b1;
    #1;
    chk(core_rst, 1'b1, "R1 async assert");
    step(2);
    por_in = 1'b0;
    step(TMO);
    chk(core_rst, 1'b1, "R1 timeout repeated");
    step(1);
    chk(core_rst, 1'b0, "R1 release after repeat");

    por_in = 1'b1;
    step(2);
    por_in = 1'b0;
    ext_rst_n = 1'b0;
    step(TMO + 1);
    chk(core_rst, 1'b1, "R4 pin low at timeout");
    step(50);
    chk(core_rst, 1'b1, "R4 still held");
    ext_rst_n = 1'b1;
    step(LAT - 1);
    chk(core_rst, 1'b1, "R4 before release");
    step(1);
    chk(core_rst, 1'b0, "R4 release edge");

    for (int i = 0; i < 40; i++) begin
      int w;
      w = int'($urandom_range(1, 8));
      ext_rst_n = 1'b0;
      step(w);
      ext_rst_n = 1'b1;
      watch(20, 1'b1, seen);
      chk(seen, exp_hit(w), exp_hit(w) ? "R5 random pulse" : "R6 random pulse");
      chk(core_rst, 1'b0, "R7 random recovery");
    end

    summary();
  end
endmodule